// File: doc/BRIEF.md
# Single-Cycle Six-Operation Integer Core

This block is a 32-bit integer processor core that finishes one instruction in every clock cycle. In that one cycle it fetches an instruction word, decodes it, reads two registers, runs the arithmetic unit, accesses data memory and writes the result back. It handles six operations: register add, register subtract, OR with an immediate, load word, store word and branch-if-equal. The program counter, a 32-entry register file, the arithmetic unit, the immediate extension, the next-PC selection and a combinational decoder all sit inside the core. So do two small word-addressed memories, one for instructions and one for data.

Both memories are filled through a preload port while reset is held. After reset is released the core starts fetching from byte address 0. It shows the effect of the instruction it is executing on a set of commit outputs: the current PC, the register write and the memory store. These outputs are valid in the cycle before the clock edge that commits them. There is no stream interface, so every pin is a plain level signal.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 and neither commit strobe is asserted. After release, the first instruction is fetched from byte address 0.
- R2: An R-type word (opcode bits 31:26 = 0x00, rs bits 25:21, rt bits 20:16, rd bits 15:11, funct bits 5:0) with funct 0x21 writes rs+rt modulo 2^32 into rd. The PC advances by 4.
- R3: The same R-type layout with funct 0x23 writes rs−rt modulo 2^32 into rd, and a borrow wraps around. The arithmetic unit forms this by inverting the second operand and adding a carry-in of 1.
- R4: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate (bits 15:0) into rt.
- R5: Opcode 0x23 loads the data word at byte address rs + sign-extended immediate into rt. Data memory is indexed by byte-address bits [DAW+1:2].
- R6: Opcode 0x2B stores rt to data memory at byte address rs + sign-extended immediate. It asserts `dm_we_o`, writes no register, and a later load from that address returns the stored value.
- R7: Opcode 0x04 with rs equal to rt sets the PC to PC+4 plus the sign-extended immediate shifted left by two. This covers both forward and backward offsets.
- R8: Opcode 0x04 with rs not equal to rt sets the PC to PC+4 and writes neither a register nor memory.
- R9: Register 0 always reads as zero. A write aimed at it leaves `rf_we_o` low and has no effect.
- R10: An unrecognised opcode, or an R-type word with a funct other than 0x21 or 0x23, writes nothing and only advances the PC by 4.
- R11: When `ld_en_i` is high, `ld_data_i` is written into word `ld_word_i`. The target is data memory when `ld_dmem_i` is 1 and instruction memory when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en_i | input | 1 | Preload write strobe |
| ld_dmem_i | input | 1 | Preload target: 1 = data memory, 0 = instruction memory |
| ld_word_i | input | LD_AW | Preload word index |
| ld_data_i | input | 32 | Preload data word |
| pc_o | output | 32 | Byte address of the instruction now executing |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value written |
| dm_we_o | output | 1 | A store commits at the next edge |
| dm_addr_o | output | 32 | Byte address of the data access |
| dm_wdata_o | output | 32 | Store data |

## Verification
The hardest case to reach from the ports is a branch whose target lies behind it. Checking it needs a taken compare with a negative offset, and that only happens once earlier instructions have put equal values in two registers. The program preloaded by the bench first builds register values with OR-immediate, add and subtract. It then takes a forward branch over two words that must not execute. Finally it lands on a branch with offset −1, which targets itself. The bench keeps checking that this self-loop holds the PC in place on every cycle. The data written by the store is read back by a later load, and a register-0 write is followed by a read of register 0. In this way the hidden state shows up on the commit outputs.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD    = 6'h21;
  localparam logic [5:0] FN_SUB    = 6'h23;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_OR = 2'd2} alu_op_e;

  typedef struct packed {
    logic    known;
    logic    rf_we;
    logic    dst_is_rt;
    logic    use_imm;
    logic    imm_zext;
    alu_op_e alu_op;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    case (opc)
      OPC_RTYPE: begin
        if (fn == FN_ADD) begin
          ctrl.known = 1'b1; ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_ADD;
        end else if (fn == FN_SUB) begin
          ctrl.known = 1'b1; ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SUB;
        end
      end
      OPC_ORI: begin
        ctrl.known = 1'b1; ctrl.rf_we = 1'b1; ctrl.dst_is_rt = 1'b1;
        ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_OR;
      end
      OPC_LW: begin
        ctrl.known = 1'b1; ctrl.rf_we = 1'b1; ctrl.dst_is_rt = 1'b1;
        ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_ADD; ctrl.mem_rd = 1'b1;
      end
      OPC_SW: begin
        ctrl.known = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_ADD;
        ctrl.mem_wr = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.known = 1'b1; ctrl.alu_op = ALU_SUB; ctrl.branch = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  // An unknown word must not disturb architectural state (R10)
  always_comb begin
    if (!ctrl.known) begin
      assert_unknown_quiet_R10: assert (!ctrl.rf_we && !ctrl.mem_wr && !ctrl.branch && !ctrl.mem_rd);
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic         inv;
  logic [W-1:0] b_x;
  logic [W-1:0] sum;

  assign inv = (op == ALU_SUB);
  assign b_x = b ^ {W{inv}};
  assign sum = a + b_x + {{(W-1){1'b0}}, inv};

  always_comb begin
    case (op)
      ALU_OR:  y = a | b;
      default: y = sum;
    endcase
  end
  assign zero = (y == '0);

  // Difference plus subtrahend must give the minuend back (R3)
  always_comb begin
    if (op == ALU_SUB) begin
      assert_sub_inverse_R3: assert (y + b == a);
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  // A committed write is visible in the following cycle (R2)
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LD_AW = (IAW > DAW) ? IAW : DAW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en_i,
  input  logic             ld_dmem_i,
  input  logic [LD_AW-1:0] ld_word_i,
  input  logic [31:0]      ld_data_i,
  output logic [31:0]      pc_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [31:0]      rf_wdata_o,
  output logic             dm_we_o,
  output logic [31:0]      dm_addr_o,
  output logic [31:0]      dm_wdata_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_off;
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, wb_val;
  logic [4:0]      f_rs, f_rt, f_rd, waddr;
  logic [15:0]     f_imm;
  logic [DAW-1:0]  dm_idx;
  logic            alu_zero, take, rf_commit, dm_commit;
  ctrl_t           ctrl;

  assign instr = imem[pc_q[IAW+1:2]];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];

  sc_decode u_dec (.opc(instr[31:26]), .fn(instr[5:0]), .ctrl(ctrl));

  assign waddr = ctrl.dst_is_rt ? f_rt : f_rd;
  assign rf_commit = ctrl.rf_we && !rst;

  sc_regfile #(.W(XLEN), .N(32)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(f_rs), .ra_b(f_rt), .rd_a(rs_val), .rd_b(rt_val),
    .we(rf_commit), .waddr(waddr), .wdata(wb_val)
  );

  assign imm_ext = ctrl.imm_zext ? {16'h0000, f_imm} : {{16{f_imm[15]}}, f_imm};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (.a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero));

  assign dm_idx    = alu_y[DAW+1:2];
  assign wb_val    = ctrl.mem_rd ? dmem[dm_idx] : alu_y;
  assign dm_commit = ctrl.mem_wr && !rst;

  assign pc_plus4 = pc_q + 32'd4;
  assign br_off   = {imm_ext[29:0], 2'b00};
  assign take     = ctrl.branch && alu_zero;
  assign pc_next  = take ? pc_plus4 + br_off : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (ld_en_i && !ld_dmem_i) imem[ld_word_i[IAW-1:0]] <= ld_data_i;
  end

  always_ff @(posedge clk) begin
    if (ld_en_i && ld_dmem_i) dmem[ld_word_i[DAW-1:0]] <= ld_data_i;
    else if (dm_commit)       dmem[dm_idx] <= rt_val;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_commit && (waddr != 5'd0);
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_val;
  assign dm_we_o    = dm_commit;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], imm_ext[31:30], ctrl.known};

  assert_reset_pc_R1: assert property (@(posedge clk) rst |=> pc_q == '0);

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc_q == $past(pc_q) + 32'd4);

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> pc_q == $past(pc_q) + 32'd4 + $past(br_off));

  assert_store_lands_R6: assert property (@(posedge clk) disable iff (rst)
    (dm_commit && !ld_en_i) |=> dmem[$past(dm_idx)] == $past(rt_val));
endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  localparam int LD_AW = 6;

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic        dmwe;
    logic [31:0] dmaddr;
    logic [31:0] dmwdata;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, ld_dmem = 1'b0;
  logic [LD_AW-1:0] ld_word = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  item_t exp_q[$];

  logic [31:0] prog [64];
  logic [31:0] m_mem [64];
  logic [31:0] m_reg [32];

  always #4 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst), .ld_en_i(ld_en), .ld_dmem_i(ld_dmem),
    .ld_word_i(ld_word), .ld_data_i(ld_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic load_word(bit to_dmem, int idx, logic [31:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = to_dmem; ld_word = LD_AW'(idx); ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Driver: reference stepping from the requirements, pushing expected commits
  task automatic drive_expected(int steps);
    logic [31:0] pc = 0;
    for (int s = 0; s < steps; s++) begin
      item_t e;
      logic [31:0] ins, a, b, sx, nxt;
      logic [5:0] op, fn;
      int rs, rt, rd;
      ins = prog[pc[7:2]];
      op = ins[31:26]; fn = ins[5:0];
      rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
      a = m_reg[rs]; b = m_reg[rt];
      sx = {{16{ins[15]}}, ins[15:0]};
      nxt = pc + 4;
      e.pc = pc; e.we = 0; e.waddr = 0; e.wdata = 0;
      e.dmwe = 0; e.dmaddr = 0; e.dmwdata = 0; e.tag = "R10";
      if (op == 6'h00 && fn == 6'h21) begin
        e.we = 1; e.waddr = 5'(rd); e.wdata = a + b; e.tag = (rs == 0 && rt == 0) ? "R9" : "R2";
      end else if (op == 6'h00 && fn == 6'h23) begin
        e.we = 1; e.waddr = 5'(rd); e.wdata = a - b; e.tag = "R3";
      end else if (op == 6'h0D) begin
        e.we = 1; e.waddr = 5'(rt); e.wdata = a | {16'h0, ins[15:0]}; e.tag = (rt == 0) ? "R9" : "R4";
      end else if (op == 6'h23) begin
        e.we = 1; e.waddr = 5'(rt); e.wdata = m_mem[(a + sx) >> 2]; e.tag = "R5";
      end else if (op == 6'h2B) begin
        e.dmwe = 1; e.dmaddr = a + sx; e.dmwdata = b; e.tag = "R6";
        m_mem[(a + sx) >> 2] = b;
      end else if (op == 6'h04) begin
        if (a == b) begin nxt = pc + 4 + {sx[29:0], 2'b00}; e.tag = "R7"; end
        else e.tag = "R8";
      end
      if (e.we && e.waddr == 0) e.we = 0;
      if (e.we) m_reg[e.waddr] = e.wdata;
      if (s == 0) e.tag = {e.tag, " R1 R11"};
      exp_q.push_back(e);
      pc = nxt;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin prog[i] = 32'h0; m_mem[i] = 32'h0; end
    for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
    prog[0]  = enc_i(6'h0D, 0, 1, 16'h0010);
    prog[1]  = enc_i(6'h0D, 0, 2, 16'hFFFF);
    prog[2]  = enc_r(1, 2, 3, 6'h21);
    prog[3]  = enc_r(1, 2, 4, 6'h23);
    prog[4]  = enc_i(6'h23, 1, 5, 16'h0000);
    prog[5]  = enc_i(6'h23, 1, 6, 16'h0004);
    prog[6]  = enc_i(6'h23, 1, 7, 16'hFFFC);
    prog[7]  = enc_i(6'h2B, 1, 3, 16'h0008);
    prog[8]  = enc_i(6'h23, 0, 8, 16'h0018);
    prog[9]  = enc_i(6'h0D, 0, 0, 16'h1234);
    prog[10] = enc_r(0, 0, 9, 6'h21);
    prog[11] = enc_i(6'h04, 1, 2, 16'h0005);
    prog[12] = enc_r(1, 1, 10, 6'h20);
    prog[13] = enc_i(6'h3F, 1, 11, 16'h0001);
    prog[14] = enc_i(6'h04, 5, 5, 16'h0002);
    prog[15] = enc_i(6'h0D, 0, 13, 16'h00AA);
    prog[16] = enc_r(1, 1, 14, 6'h21);
    prog[17] = enc_r(12, 1, 12, 6'h23);
    prog[18] = enc_i(6'h04, 0, 0, 16'hFFFF);
    m_mem[3] = 32'h0BAD_F00D;
    m_mem[4] = 32'hDEAD_BEEF;
    m_mem[5] = 32'h1234_5678;
  end

  // Stimulus and reset-state checks
  initial begin
    #1;
    for (int i = 0; i < 64; i++) load_word(1'b0, i, prog[i]);
    for (int i = 0; i < 64; i++) load_word(1'b1, i, m_mem[i]);
    @(negedge clk);
    check(pc_o == 32'h0, "R1", "pc in reset", pc_o, 32'h0);
    check(!rf_we_o && !dm_we_o, "R1", "strobes in reset", {30'h0, rf_we_o, dm_we_o}, 32'h0);
    drive_expected(30);
    @(negedge clk);
    rst = 1'b0;
  end

  // Monitor: compare the design's commit outputs against the queue
  initial begin
    @(negedge rst);
    #1;
    while (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      check(pc_o == e.pc, e.tag, "pc", pc_o, e.pc);
      check(rf_we_o == e.we && dm_we_o == e.dmwe, e.tag, "strobes",
            {30'h0, rf_we_o, dm_we_o}, {30'h0, e.we, e.dmwe});
      if (e.we) begin
        check(rf_waddr_o == e.waddr, e.tag, "waddr", 32'(rf_waddr_o), 32'(e.waddr));
        check(rf_wdata_o == e.wdata, e.tag, "wdata", rf_wdata_o, e.wdata);
      end
      if (e.dmwe) begin
        check(dm_addr_o == e.dmaddr, e.tag, "store addr", dm_addr_o, e.dmaddr);
        check(dm_wdata_o == e.dmwdata, e.tag, "store data", dm_wdata_o, e.dmwdata);
      end
      @(negedge clk);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #(8 * 20000);
    join_any
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule